// File: doc/BRIEF.md
# Accelerator Revolution Clock Generator

This block runs on the event clock, which is the RF master frequency divided by four (about 124.9 MHz for a 499.654 MHz RF). From it, three free-running dividers produce square-wave clocks:

- the booster revolution clock (divide by 207);
- the storage-ring revolution clock (divide by 216);
- the coincidence clock (divide by 4968), at which 24 booster turns and 23 storage-ring turns line up.

A synchronous resync input clears every counter at once, so the three clocks restart in phase.

A mains tick input, one event-clock cycle per mains edge, feeds a programmable repetition divider. Divisors of 20, 24, 30, 40 or 60 give injection rates between 3 Hz and 1 Hz. Each repetition strobe then waits a programmable phase delay, counted in 100 µs ticks derived from the event clock. The delayed strobe is not used directly. It is held until the next rising edge of the coincidence clock and only then issued as a one-cycle sequencer start.

The three clocks and the start pulse each drive one bit of an 8-bit distributed bus.

Top module: `rev_clk_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `dbus` reads 8'h07 and `seq_start` is 0.
- R2: `dbus[0]` has a period of BR_DIV cycles (207 by default). It is high for ceil(BR_DIV/2) of them (104), starting with the first cycle after a resync.
- R3: `dbus[1]` has a period of SR_DIV cycles (216 by default). It is high for ceil(SR_DIV/2) of them (108), starting with the first cycle after a resync.
- R4: `dbus[2]` has a period of CO_DIV cycles (4968 by default) and is high for 2484 of them. Every rising edge of `dbus[2]` that is not caused by a resync falls in the same cycle as a rising edge of both `dbus[0]` and `dbus[1]`.
- R5: When `resync` is high in cycle r, cycle r+1 shows `dbus[2:0]` = 3'b111 and `seq_start` = 0. All counters restart from zero, and a start request not yet issued is discarded.
- R6: A repetition strobe is raised on every N-th `mains_tick`, where N is `rep_div` and the value 0 means 256. Fewer than N ticks never lead to a start.
- R7: The delayed strobe appears 3 + `phase_dly`·TICK_DIV cycles after the cycle of the mains tick that completes the count. With the default TICK_DIV of 12491, one tick is 100 µs.
- R8: `seq_start` is a one-cycle pulse in the first cycle after the delayed strobe in which `dbus[2]` rises. If the strobe lands in the last cycle before that rise, the start follows in the very next cycle.
- R9: `dbus[3]` equals `seq_start`, and `dbus[7:4]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock (RF/4) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| resync | input | 1 | Synchronous clear of all counters and of any pending start |
| mains_tick | input | 1 | One-cycle pulse per mains edge |
| rep_div | input | 8 | Repetition divisor, 1 to 255, with 0 selecting 256 |
| phase_dly | input | 8 | Phase delay in 100 µs ticks (0 to 25.5 ms) |
| dbus | output | 8 | Distributed bus: [0] booster, [1] storage ring, [2] coincidence, [3] start, [7:4] zero |
| seq_start | output | 1 | Sequencer start pulse aligned to the coincidence clock |

## Verification
Two events can land in the same cycle: the delayed repetition strobe and the wrap of the coincidence counter. When they coincide, the start must go out in the next cycle rather than one coincidence period later.

The bench places the final mains tick so that the strobe arrives exactly in the wrap cycle, and again one cycle after it. From the resync cycle and R7 it computes the single cycle in which the pulse is allowed, and accepts only a single pulse in exactly that cycle, coinciding with a rising edge of `dbus[2]`.

// File: rtl/rcg_pkg.sv
`timescale 1ns/1ps
package rcg_pkg;
  localparam int BUS_W     = 8;
  localparam int NUM_CLK   = 3;
  localparam int BIT_BR    = 0;
  localparam int BIT_SR    = 1;
  localparam int BIT_CO    = 2;
  localparam int BIT_START = 3;

  function automatic int half_up(input int d);
    return (d + 1) / 2;
  endfunction
endpackage

// File: rtl/rcg_divider.sv
`timescale 1ns/1ps
module rcg_divider #(
  parameter int DIV = 207
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic clk_out,
  output logic wrap
);
  import rcg_pkg::*;
  localparam int CW = (DIV < 2) ? 1 : $clog2(DIV);
  localparam int HI = half_up(DIV);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          out_q, out_d;

  always_comb begin
    wrap = (cnt_q == CW'(DIV - 1));
    if (clr || wrap) cnt_d = '0;
    else             cnt_d = cnt_q + CW'(1);
    out_d = (cnt_d < CW'(HI));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign clk_out = out_q;
endmodule

// File: rtl/rcg_rep_div.sv
`timescale 1ns/1ps
module rcg_rep_div #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [RW-1:0] divisor,
  output logic          strobe
);
  logic [RW-1:0] cnt_q, cnt_d, lim;
  logic          hit, str_q, str_d;

  always_comb begin
    lim   = divisor - RW'(1);
    hit   = tick && (cnt_q >= lim);
    cnt_d = cnt_q;
    str_d = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (hit) begin
      cnt_d = '0;
      str_d = 1'b1;
    end else if (tick) begin
      cnt_d = cnt_q + RW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      str_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      str_q <= str_d;
    end
  end

  assign strobe = str_q;
endmodule

// File: rtl/rcg_phase_dly.sv
`timescale 1ns/1ps
module rcg_phase_dly #(
  parameter int DW       = 8,
  parameter int TICK_DIV = 12491
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          trig,
  input  logic [DW-1:0] delay,
  output logic          strobe
);
  localparam int PW = $clog2(TICK_DIV + 1);

  logic [PW-1:0] psc_q, psc_d;
  logic [DW-1:0] dly_q, dly_d;
  logic          busy_q, busy_d, str_q, str_d, psc_wrap;

  always_comb begin
    psc_wrap = (psc_q == PW'(TICK_DIV - 1));
    psc_d    = psc_q;
    dly_d    = dly_q;
    busy_d   = busy_q;
    str_d    = 1'b0;
    if (clr) begin
      psc_d  = '0;
      dly_d  = '0;
      busy_d = 1'b0;
    end else if (trig) begin
      psc_d  = '0;
      dly_d  = delay;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (dly_q == '0) begin
        busy_d = 1'b0;
        str_d  = 1'b1;
      end else if (psc_wrap) begin
        psc_d = '0;
        dly_d = dly_q - DW'(1);
      end else begin
        psc_d = psc_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q  <= '0;
      dly_q  <= '0;
      busy_q <= 1'b0;
      str_q  <= 1'b0;
    end else begin
      psc_q  <= psc_d;
      dly_q  <= dly_d;
      busy_q <= busy_d;
      str_q  <= str_d;
    end
  end

  assign strobe = str_q;
endmodule

// File: rtl/rcg_align.sv
`timescale 1ns/1ps
module rcg_align (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic req,
  input  logic coin_wrap,
  output logic start
);
  logic pend_q, pend_d, st_q, st_d;

  always_comb begin
    pend_d = pend_q;
    st_d   = 1'b0;
    if (clr) begin
      pend_d = 1'b0;
    end else if ((req || pend_q) && coin_wrap) begin
      pend_d = 1'b0;
      st_d   = 1'b1;
    end else if (req) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      st_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      st_q   <= st_d;
    end
  end

  assign start = st_q;
endmodule

// File: rtl/rev_clk_gen.sv
`timescale 1ns/1ps
module rev_clk_gen #(
  parameter int BR_DIV   = 207,
  parameter int SR_DIV   = 216,
  parameter int CO_DIV   = 4968,
  parameter int TICK_DIV = 12491,
  parameter int REP_W    = 8,
  parameter int DLY_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             resync,
  input  logic             mains_tick,
  input  logic [REP_W-1:0] rep_div,
  input  logic [DLY_W-1:0] phase_dly,
  output logic [7:0]       dbus,
  output logic             seq_start
);
  import rcg_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_q    <= rst_meta_q;
    end
  end

  logic [NUM_CLK-1:0] clk_bits, clk_wrap;

  for (genvar gi = 0; gi < NUM_CLK; gi++) begin : g_div
    localparam int D = (gi == BIT_BR) ? BR_DIV : (gi == BIT_SR) ? SR_DIV : CO_DIV;
    rcg_divider #(.DIV(D)) u_div (
      .clk    (clk),
      .rst_n  (rst_s_q),
      .clr    (resync),
      .clk_out(clk_bits[gi]),
      .wrap   (clk_wrap[gi])
    );
  end

  logic rep_str, dly_str, start;

  rcg_rep_div #(.RW(REP_W)) u_rep (
    .clk    (clk),
    .rst_n  (rst_s_q),
    .clr    (resync),
    .tick   (mains_tick),
    .divisor(rep_div),
    .strobe (rep_str)
  );

  rcg_phase_dly #(.DW(DLY_W), .TICK_DIV(TICK_DIV)) u_dly (
    .clk   (clk),
    .rst_n (rst_s_q),
    .clr   (resync),
    .trig  (rep_str),
    .delay (phase_dly),
    .strobe(dly_str)
  );

  rcg_align u_align (
    .clk      (clk),
    .rst_n    (rst_s_q),
    .clr      (resync),
    .req      (dly_str),
    .coin_wrap(clk_wrap[BIT_CO]),
    .start    (start)
  );

  always_comb begin
    dbus                       = '0;
    dbus[NUM_CLK-1:0]          = clk_bits;
    dbus[BIT_START]            = start;
  end
  assign seq_start = start;
endmodule

// File: rtl/rcg_chk.sv
`timescale 1ns/1ps
module rcg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       resync,
  input logic [7:0] dbus,
  input logic       seq_start
);
  // R4
  coinc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dbus[2]) && !$past(resync)) |-> ($rose(dbus[0]) && $rose(dbus[1])));

  // R5
  resync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(resync) |-> (dbus[2:0] == 3'b111 && !seq_start));

  // R8
  start_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> $rose(dbus[2]));

  // R8
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> !seq_start);

  // R9
  bus_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbus[3] == seq_start) && (dbus[7:4] == 4'h0));
endmodule

bind rev_clk_gen rcg_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .resync   (resync),
  .dbus     (dbus),
  .seq_start(seq_start)
);

// File: tb/rev_clk_gen_tb.sv
`timescale 1ns/1ps
module rev_clk_gen_tb;
  localparam int BR = 207, SR = 216, CO = 4968, TK = 20;

  logic       clk = 1'b0;
  logic       rst_n, resync, mains_tick;
  logic [7:0] rep_div, phase_dly, dbus;
  logic       seq_start;
  longint     cyc = 0;
  longint     rs_cyc = 0;
  int         n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rev_clk_gen #(.BR_DIV(BR), .SR_DIV(SR), .CO_DIV(CO), .TICK_DIV(TK)) u_dut (
    .clk(clk), .rst_n(rst_n), .resync(resync), .mains_tick(mains_tick),
    .rep_div(rep_div), .phase_dly(phase_dly), .dbus(dbus), .seq_start(seq_start)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_resync();
    @(negedge clk);
    rs_cyc = cyc;
    resync = 1'b1;
    @(negedge clk);
    resync = 1'b0;
  endtask

  task automatic pulse_tick();
    mains_tick = 1'b1;
    @(negedge clk);
    mains_tick = 1'b0;
  endtask

  // R2 R3 R4 R5: high time and period measured from the cycle after resync
  task automatic measure(input int idx, input int per, input string tag);
    int hi = 0, p = 0;
    bit prev_lo;
    do_resync();
    check(dbus[2:0] == 3'b111, "R5 all clocks high after resync", dbus[2:0], 7);
    while (dbus[idx]) begin hi++; @(negedge clk); end
    p = hi;
    while (!dbus[idx]) begin
      p++;
      prev_lo = (dbus[1:0] == 2'b00);
      @(negedge clk);
    end
    check(hi == (per + 1) / 2, {tag, " high time"}, hi, (per + 1) / 2);
    check(p == per, {tag, " period"}, p, per);
    if (idx == 2)
      check(prev_lo && dbus[1:0] == 2'b11, "R4 revolution clocks rise with coincidence",
            dbus[1:0], 3);
  endtask

  function automatic longint exp_start(input longint m, input int d, input longint r);
    longint s = m + 3 + longint'(d) * TK + 1;
    while (((s - r - 1) % CO) != 0) s++;
    return s;
  endfunction

  // R6 R7 R8 R9: last tick placed so the strobe lands 'off' cycles after a wrap
  task automatic start_case(input int n, input int d, input int off, input string tag);
    int     neff = (n == 0) ? 256 : n;
    longint m, s, first = -1;
    int     k = 2, cnt = 0, early = 0;
    bit     rose_ok = 1'b0, map_ok = 1'b1;
    logic   prev2;
    rep_div   = 8'(n);
    phase_dly = 8'(d);
    do_resync();
    for (int i = 0; i < neff - 1; i++) pulse_tick();
    m = rs_cyc + longint'(k) * CO - 3 - longint'(d) * TK + off;
    while (m <= cyc + 1) begin k++; m = rs_cyc + longint'(k) * CO - 3 - longint'(d) * TK + off; end
    while (cyc < m) begin
      if (seq_start) early++;
      @(negedge clk);
    end
    check(early == 0, {"R6 no start before count complete ", tag}, early, 0);
    s = exp_start(m, d, rs_cyc);
    prev2 = dbus[2];
    pulse_tick();
    while (cyc <= s + 8) begin
      if (dbus[3] != seq_start || dbus[7:4] != 4'h0) map_ok = 1'b0;
      if (seq_start) begin
        cnt++;
        if (first < 0) begin first = cyc; rose_ok = !prev2 && dbus[2]; end
      end
      prev2 = dbus[2];
      @(negedge clk);
    end
    check(first == s, {"R7 R8 start cycle ", tag}, first - rs_cyc, s - rs_cyc);
    check(cnt == 1, {"R8 single start pulse ", tag}, cnt, 1);
    check(rose_ok, {"R8 start on coincidence rise ", tag}, rose_ok, 1);
    check(map_ok, {"R9 bus bit mapping ", tag}, map_ok, 1);
  endtask

  // R5: resync after the strobe but before the wrap drops the request
  task automatic resync_cancel();
    int cnt = 0;
    rep_div = 8'd1; phase_dly = 8'd0;
    do_resync();
    repeat (50) @(negedge clk);
    pulse_tick();
    repeat (10) @(negedge clk);
    do_resync();
    repeat (2 * CO + 10) begin
      if (seq_start) cnt++;
      @(negedge clk);
    end
    check(cnt == 0, "R5 pending start discarded by resync", cnt, 0);
  endtask

  // R5: resync while the booster clock is low
  task automatic resync_low();
    while (dbus[0]) @(negedge clk);
    do_resync();
    check(dbus[2:0] == 3'b111, "R5 resync while low", dbus[2:0], 7);
  endtask

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; resync = 1'b0; mains_tick = 1'b0;
    rep_div = 8'd1; phase_dly = 8'd0;
    repeat (3) @(negedge clk);
    check(dbus == 8'h07 && !seq_start, "R1 reset state", dbus, 7);
    rst_n = 1'b1;
    @(negedge clk);
    check(dbus == 8'h07 && !seq_start, "R1 state after release", dbus, 7);
    repeat (4) @(negedge clk);

    measure(0, BR, "R2 booster clock");
    measure(1, SR, "R3 ring clock");
    measure(2, CO, "R4 coincidence clock");
    resync_low();
    resync_cancel();

    start_case(1,   0,   0, "same-cycle wrap");
    start_case(1,   0,   1, "one past wrap");
    start_case(3,   5,   0, "divide 3 delay 5");
    start_case(1,   255, 7, "max delay");
    start_case(0,   0,   40, "divide 256");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule